// File: doc/BRIEF.md
# PLL control and reset conditioner

This block is the soft control logic placed next to a clock-synthesis PLL. It takes the raw, active-low powerdown, bypass and reset pins and a supply-ready qualifier, and turns them into clean powerdown, bypass and reset commands for the PLL core. All synchronisation uses a free-running calibration clock of 50 MHz or less. The block also picks the output clock, qualifies the core's raw lock flag, and pulses a calibration-start strobe each time the core leaves reset.

The three controls follow a fixed priority. Powerdown beats bypass, and bypass beats reset. Powerdown stops the output clock and shuts the core down. Bypass shuts the core down and passes the reference clock straight through. Reset holds the core in reset but leaves the output on the core clock.

A parameter selects between two ways of handling the reset pin:
- Synchronous: the reset pin is filtered, and only a low pulse at least three calibration cycles long is accepted.
- Asynchronous-assert, synchronous-release: the internal reset asserts at once and is released through a synchroniser chain.

Top module: `pll_ctrl_cond`

## Requirements
- R1: While `por_n` is low, `core_pdn`=1, `core_byp`=0, `core_rst`=1, `lock_out`=0 and `clk_out`=0.
- R2: With `pdn_n`=0, `core_pdn`=1, `core_byp`=0, `lock_out`=0 and `clk_out` stays low, whatever `byp_n` and `rst_n` are.
- R3: With `pdn_n`=1 and `byp_n`=0, `core_pdn`=1 and `core_byp`=1. Once the clock switch has settled, `clk_out` shows exactly the rising edges of `ref_clk`, even while the core is held in reset. The two clock branches are never enabled together.
- R4: With `pdn_n`=1 and `byp_n`=1, `core_pdn`=0 and `core_byp`=0. Once the switch has settled, `clk_out` shows exactly the rising edges of `core_clk`.
- R5: In synchronous mode (`RST_MODE`=`RST_SYNC`), `rst_n` is sampled on `cal_clk` rising edges:
  - a low level seen on at least 3 consecutive edges asserts `core_rst`;
  - a low level seen on 2 or fewer edges never asserts it.
- R6: In asynchronous-assert mode (`RST_MODE`=`RST_ASYNC`), `core_rst` rises in the same time step in which `rst_n` falls. After `rst_n` returns high, `core_rst` is released on the third `cal_clk` rising edge (default `SYNC_STAGES`=2).
- R7: While the synchronised `supply_ok` is low, `core_rst` is held asserted. With `supply_ok` tied high, it has no effect on the reset.
- R8: `cal_start` is a pulse exactly one `cal_clk` cycle long. It is high in the first cycle in which `core_rst` is low after having been high. It occurs once after power-on release and once after every later reset release.
- R9: `lock_out` rises only after `core_lock` has passed a 2-flop synchroniser and been seen high on 4 consecutive `cal_clk` edges. If `core_lock` rises between edges, `lock_out` is high after the 6th following edge and low after the 5th. It falls after the 2nd edge once `core_lock` drops.
- R10: `lock_out` is forced low in the same time step whenever powerdown, bypass or `core_rst` is active. After that, it re-qualifies as in R9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cal_clk | input | 1 | Free-running calibration clock, at most 50 MHz |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| pdn_n | input | 1 | Powerdown request, active low, highest priority |
| byp_n | input | 1 | Bypass request, active low |
| rst_n | input | 1 | PLL reset request, active low |
| supply_ok | input | 1 | PLL supply ready, active high |
| ref_clk | input | 1 | Reference clock, used as output clock in bypass |
| core_clk | input | 1 | Raw output clock of the PLL core |
| core_lock | input | 1 | Raw lock flag of the PLL core |
| core_pdn | output | 1 | Powerdown command to the core, active high |
| core_byp | output | 1 | Bypass command to the core, active high |
| core_rst | output | 1 | Reset command to the core, active high |
| clk_out | output | 1 | Selected output clock |
| lock_out | output | 1 | Qualified lock flag, active high |
| cal_start | output | 1 | One-cycle calibration-start strobe |

## Verification
The assertions assume the following about the inputs:
- every pin changes well away from a rising edge of `cal_clk`;
- `por_n` is applied before anything else;
- all three clocks keep running.

The bench drives every input one nanosecond after a falling calibration edge, holds `por_n` low for several cycles at the start, and never stops the clocks. It places reset pulses so that each covers a known number of rising edges (two and three), which makes the filter's accept/reject threshold exact. `core_lock` only moves at quiet points, so the lock-history property sees a clean run of synchronised samples.

// File: rtl/pcc_pkg.sv
package pcc_pkg;

  typedef enum logic {
    RST_SYNC  = 1'b0,
    RST_ASYNC = 1'b1
  } rst_mode_e;

  // saturating increment of a run counter
  function automatic int unsigned sat_inc(input int unsigned v, input int unsigned lim);
    return (v >= lim) ? lim : v + 1;
  endfunction

  // a run of `need` samples has been seen
  function automatic logic run_complete(input int unsigned run, input int unsigned need);
    return run >= need;
  endfunction

  // low-width filter: the current low sample completes the required run
  function automatic logic filter_fires(input logic low_now, input int unsigned run,
                                        input int unsigned need);
    return low_now && (run + 1 >= need);
  endfunction

endpackage

// File: rtl/pcc_clk_branch.sv
// One leg of the glitch-free clock switch: arms on the rising edge of its own
// clock, enables on the falling edge, and waits for the other leg to be off.
module pcc_clk_branch (
  input  logic src_clk,
  input  logic por_n,
  input  logic want,
  input  logic other_on,
  output logic on,
  output logic gclk
);

  logic arm_q;
  logic on_q;

  always_ff @(posedge src_clk or negedge por_n) begin
    if (!por_n) arm_q <= 1'b0;
    else        arm_q <= want & ~other_on;
  end

  always_ff @(negedge src_clk or negedge por_n) begin
    if (!por_n) on_q <= 1'b0;
    else        on_q <= arm_q;
  end

  assign on   = on_q;
  assign gclk = src_clk & on_q;

endmodule

// File: rtl/pcc_rst_cond.sv
// Reset conditioner on the calibration clock: pin synchroniser (style chosen by
// parameter), supply qualifier, registered core reset and calibration strobe.
module pcc_rst_cond
  import pcc_pkg::*;
#(
  parameter rst_mode_e   RST_MODE    = RST_SYNC,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned MIN_LOW     = 3
) (
  input  logic cal_clk,
  input  logic por_n,
  input  logic rst_n,
  input  logic supply_ok,
  output logic rst_req,
  output logic sup_sync,
  output logic core_rst,
  output logic cal_start
);

  localparam int unsigned LW = $clog2(MIN_LOW + 1);

  logic arst;
  logic req;

  generate
    if (RST_MODE == RST_SYNC) begin : g_sync
      logic [SYNC_STAGES:0] smp;
      logic [LW-1:0]        lowcnt;
      logic                 req_q;
      logic                 low_now;

      assign arst    = ~por_n;
      assign low_now = ~smp[SYNC_STAGES];

      always_ff @(posedge cal_clk or posedge arst) begin
        if (arst) begin
          smp    <= '0;
          lowcnt <= '0;
          req_q  <= 1'b1;
        end else begin
          smp <= {smp[SYNC_STAGES-1:0], rst_n};
          if (!low_now) begin
            lowcnt <= '0;
            req_q  <= 1'b0;
          end else begin
            lowcnt <= LW'(sat_inc(32'(lowcnt), MIN_LOW));
            if (filter_fires(low_now, 32'(lowcnt), MIN_LOW)) req_q <= 1'b1;
          end
        end
      end

      assign req = req_q;
    end else begin : g_async
      logic [SYNC_STAGES-1:0] smp;

      assign arst = ~por_n | ~rst_n;

      always_ff @(posedge cal_clk or posedge arst) begin
        if (arst) smp <= '0;
        else      smp <= {smp[SYNC_STAGES-2:0], 1'b1};
      end

      assign req = ~smp[SYNC_STAGES-1];
    end
  endgenerate

  logic [SYNC_STAGES-1:0] sup_q;

  always_ff @(posedge cal_clk or negedge por_n) begin
    if (!por_n) sup_q <= '0;
    else        sup_q <= {sup_q[SYNC_STAGES-2:0], supply_ok};
  end

  assign sup_sync = sup_q[SYNC_STAGES-1];

  logic hold_next;
  logic rst_q;
  logic cal_q;

  assign hold_next = req | ~sup_sync;

  always_ff @(posedge cal_clk or posedge arst) begin
    if (arst) begin
      rst_q <= 1'b1;
      cal_q <= 1'b0;
    end else begin
      rst_q <= hold_next;
      cal_q <= rst_q & ~hold_next;
    end
  end

  assign rst_req   = req;
  assign core_rst  = rst_q;
  assign cal_start = cal_q;

endmodule

// File: rtl/pcc_lock_qual.sv
// Lock qualifier: synchronise the raw flag, count a run of high samples while
// enabled, and gate the result combinationally with the enable.
module pcc_lock_qual
  import pcc_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned LOCK_CYCLES = 4
) (
  input  logic cal_clk,
  input  logic por_n,
  input  logic lock_raw,
  input  logic enable,
  output logic lock_sync,
  output logic lock_out
);

  localparam int unsigned CW = $clog2(LOCK_CYCLES + 1);

  logic [SYNC_STAGES-1:0] ls;
  logic [CW-1:0]          cnt;

  assign lock_sync = ls[SYNC_STAGES-1];

  always_ff @(posedge cal_clk or negedge por_n) begin
    if (!por_n) begin
      ls  <= '0;
      cnt <= '0;
    end else begin
      ls <= {ls[SYNC_STAGES-2:0], lock_raw};
      if (enable && lock_sync) cnt <= CW'(sat_inc(32'(cnt), LOCK_CYCLES));
      else                     cnt <= '0;
    end
  end

  assign lock_out = enable & lock_sync & run_complete(32'(cnt), LOCK_CYCLES);

endmodule

// File: rtl/pll_ctrl_cond.sv
module pll_ctrl_cond
  import pcc_pkg::*;
#(
  parameter rst_mode_e   RST_MODE    = RST_SYNC,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned MIN_RST_LOW = 3,
  parameter int unsigned LOCK_CYCLES = 4
) (
  input  logic cal_clk,
  input  logic por_n,
  input  logic pdn_n,
  input  logic byp_n,
  input  logic rst_n,
  input  logic supply_ok,
  input  logic ref_clk,
  input  logic core_clk,
  input  logic core_lock,
  output logic core_pdn,
  output logic core_byp,
  output logic core_rst,
  output logic clk_out,
  output logic lock_out,
  output logic cal_start
);

  localparam int unsigned NSRC = 2;  // index 0: core clock, 1: reference

  // priority decode
  logic pdn_ok;
  logic sel_byp;
  logic sel_run;
  logic lock_en;

  assign pdn_ok   = por_n & pdn_n;
  assign sel_byp  = pdn_ok & ~byp_n;
  assign sel_run  = pdn_ok & byp_n;
  assign core_pdn = ~sel_run;
  assign core_byp = sel_byp;

  // reset path
  logic rst_req;
  logic sup_sync;

  pcc_rst_cond #(
    .RST_MODE   (RST_MODE),
    .SYNC_STAGES(SYNC_STAGES),
    .MIN_LOW    (MIN_RST_LOW)
  ) rst_i (
    .cal_clk  (cal_clk),
    .por_n    (por_n),
    .rst_n    (rst_n),
    .supply_ok(supply_ok),
    .rst_req  (rst_req),
    .sup_sync (sup_sync),
    .core_rst (core_rst),
    .cal_start(cal_start)
  );

  // lock path
  logic lock_sync;

  assign lock_en = sel_run & ~core_rst;

  pcc_lock_qual #(
    .SYNC_STAGES(SYNC_STAGES),
    .LOCK_CYCLES(LOCK_CYCLES)
  ) lock_i (
    .cal_clk  (cal_clk),
    .por_n    (por_n),
    .lock_raw (core_lock),
    .enable   (lock_en),
    .lock_sync(lock_sync),
    .lock_out (lock_out)
  );

  // glitch-free output clock switch
  logic [NSRC-1:0] src_clk;
  logic [NSRC-1:0] want;
  logic [NSRC-1:0] branch_on;
  logic [NSRC-1:0] gclk;

  assign src_clk = {ref_clk, core_clk};
  assign want    = {sel_byp, sel_run};

  generate
    for (genvar g = 0; g < NSRC; g++) begin : g_leg
      pcc_clk_branch leg_i (
        .src_clk (src_clk[g]),
        .por_n   (por_n),
        .want    (want[g]),
        .other_on(branch_on[NSRC-1-g]),
        .on      (branch_on[g]),
        .gclk    (gclk[g])
      );
    end
  endgenerate

  assign clk_out = pdn_ok & (|gclk);

endmodule

// File: rtl/pcc_chk.sv
module pcc_chk
  import pcc_pkg::*;
#(
  parameter rst_mode_e RST_MODE = RST_SYNC
) (
  input logic       cal_clk,
  input logic       por_n,
  input logic       pdn_n,
  input logic       byp_n,
  input logic       rst_n,
  input logic       core_pdn,
  input logic       core_byp,
  input logic       core_rst,
  input logic       lock_out,
  input logic       cal_start,
  input logic       lock_sync,
  input logic       sup_sync,
  input logic [1:0] branch_on
);

  // R2
  pdn_forces_chk: assert property (@(posedge cal_clk) disable iff (!por_n)
    !pdn_n |-> (core_pdn && !core_byp && !lock_out));

  // R3
  byp_forces_chk: assert property (@(posedge cal_clk) disable iff (!por_n)
    (pdn_n && !byp_n) |-> (core_pdn && core_byp && !lock_out));

  // R3
  switch_excl_chk: assert property (@(posedge cal_clk) disable iff (!por_n)
    $onehot0(branch_on));

  // R7
  supply_hold_chk: assert property (@(posedge cal_clk) disable iff (!por_n)
    !sup_sync |=> core_rst);

  // R8
  cal_single_chk: assert property (@(posedge cal_clk) disable iff (!por_n)
    cal_start |=> !cal_start);

  // R8
  cal_release_chk: assert property (@(posedge cal_clk) disable iff (!por_n)
    cal_start |-> (!core_rst && $past(core_rst)));

  // R9
  lock_history_chk: assert property (@(posedge cal_clk) disable iff (!por_n)
    $rose(lock_out) |-> ($past(lock_sync, 1) && $past(lock_sync, 2) && $past(lock_sync, 3)));

  // R10
  rst_lock_chk: assert property (@(posedge cal_clk) disable iff (!por_n)
    core_rst |-> !lock_out);

  generate
    if (RST_MODE == RST_ASYNC) begin : g_async_chk
      // R6
      async_assert_chk: assert property (@(posedge cal_clk) disable iff (!por_n)
        !rst_n |-> core_rst);
    end
  endgenerate

endmodule

bind pll_ctrl_cond pcc_chk #(.RST_MODE(RST_MODE)) chk_i (
  .cal_clk  (cal_clk),
  .por_n    (por_n),
  .pdn_n    (pdn_n),
  .byp_n    (byp_n),
  .rst_n    (rst_n),
  .core_pdn (core_pdn),
  .core_byp (core_byp),
  .core_rst (core_rst),
  .lock_out (lock_out),
  .cal_start(cal_start),
  .lock_sync(lock_sync),
  .sup_sync (sup_sync),
  .branch_on(branch_on)
);

// File: tb/pll_ctrl_cond_tb_top.sv
module pll_ctrl_cond_tb_top;
  import pcc_pkg::*;

  logic cal_clk = 1'b0;
  logic ref_clk = 1'b0;
  logic core_clk = 1'b0;
  always #10 cal_clk = ~cal_clk;
  always #15 ref_clk = ~ref_clk;
  always #7  core_clk = ~core_clk;

  logic por_n = 1'b1;
  logic pdn_n = 1'b1;
  logic byp_n = 1'b1;
  logic rst_n = 1'b1;
  logic supply_ok = 1'b1;
  logic core_lock = 1'b0;

  logic pdn_i, byp_i, rst_i, co_i, lk_i, cs_i;
  logic pdn_a, byp_a, rst_a, co_a, lk_a, cs_a;

  pll_ctrl_cond #(.RST_MODE(RST_SYNC)) dut_i (
    .cal_clk(cal_clk), .por_n(por_n), .pdn_n(pdn_n), .byp_n(byp_n), .rst_n(rst_n),
    .supply_ok(supply_ok), .ref_clk(ref_clk), .core_clk(core_clk), .core_lock(core_lock),
    .core_pdn(pdn_i), .core_byp(byp_i), .core_rst(rst_i), .clk_out(co_i),
    .lock_out(lk_i), .cal_start(cs_i));

  pll_ctrl_cond #(.RST_MODE(RST_ASYNC)) dut_a (
    .cal_clk(cal_clk), .por_n(por_n), .pdn_n(pdn_n), .byp_n(byp_n), .rst_n(rst_n),
    .supply_ok(supply_ok), .ref_clk(ref_clk), .core_clk(core_clk), .core_lock(core_lock),
    .core_pdn(pdn_a), .core_byp(byp_a), .core_rst(rst_a), .clk_out(co_a),
    .lock_out(lk_a), .cal_start(cs_a));

  // event counters, each written by one process only
  int n_oi = 0, n_oa = 0, n_ref = 0, n_core = 0;
  int n_cal_i = 0, n_cal_a = 0, n_rst_rise_i = 0;
  always @(posedge co_i)     n_oi++;
  always @(posedge co_a)     n_oa++;
  always @(posedge ref_clk)  n_ref++;
  always @(posedge core_clk) n_core++;
  always @(posedge rst_i)    if (por_n) n_rst_rise_i++;
  always @(negedge cal_clk) begin
    if (por_n && cs_i) n_cal_i++;
    if (por_n && cs_a) n_cal_a++;
  end

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  task automatic chk(input string tag, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge cal_clk);
    #1;
  endtask

  // clk mode: 0 = held low, 1 = reference, 2 = core clock
  task automatic measure(input string tag, input int mode);
    int oi0, oa0, r0, c0, exp;
    oi0 = n_oi; oa0 = n_oa; r0 = n_ref; c0 = n_core;
    #600;
    exp = (mode == 0) ? 0 : (mode == 1) ? (n_ref - r0) : (n_core - c0);
    chk(tag, "sync clk_out edges", n_oi - oi0, exp);
    chk(tag, "async clk_out edges", n_oa - oa0, exp);
  endtask

  function automatic string mode_tag(input int mode);
    return (mode == 0) ? "R2" : (mode == 1) ? "R3" : "R4";
  endfunction

  // {pdn_n, byp_n, exp core_pdn, exp core_byp, clk mode[1:0]}
  localparam logic [5:0] VEC [7] = '{
    6'b110010, 6'b101101, 6'b011000, 6'b001000, 6'b110010, 6'b101101, 6'b110010
  };

  initial begin
    #2 por_n = 1'b0;
    step(3);
    // R1 safe state during power-on reset
    chk("R1", "core_pdn sync", int'(pdn_i), 1);
    chk("R1", "core_pdn async", int'(pdn_a), 1);
    chk("R1", "core_byp sync", int'(byp_i), 0);
    chk("R1", "core_rst sync", int'(rst_i), 1);
    chk("R1", "core_rst async", int'(rst_a), 1);
    chk("R1", "lock_out sync", int'(lk_i), 0);
    chk("R1", "clk_out sync", int'(co_i), 0);

    por_n = 1'b1;
    step(10);
    // R8 power-up calibration strobe
    chk("R8", "power-up cal pulses sync", n_cal_i, 1);
    chk("R8", "power-up cal pulses async", n_cal_a, 1);
    chk("R8", "core_rst released sync", int'(rst_i), 0);

    for (int k = 0; k < 7; k++) begin
      {pdn_n, byp_n} = VEC[k][5:4];
      step(10);
      chk(mode_tag(int'(VEC[k][1:0])), "core_pdn", int'(pdn_i), int'(VEC[k][3]));
      chk(mode_tag(int'(VEC[k][1:0])), "core_byp", int'(byp_a), int'(VEC[k][2]));
      measure(mode_tag(int'(VEC[k][1:0])), int'(VEC[k][1:0]));
    end

    // R9 lock qualification timing
    step(1);
    core_lock = 1'b1;
    step(5);
    chk("R9", "lock after 5 edges", int'(lk_i), 0);
    step(1);
    chk("R9", "lock after 6 edges sync", int'(lk_i), 1);
    chk("R9", "lock after 6 edges async", int'(lk_a), 1);

    // R10 forced low by bypass and powerdown
    byp_n = 1'b0; #1;
    chk("R10", "lock in bypass", int'(lk_i), 0);
    byp_n = 1'b1;
    step(8);
    chk("R10", "lock re-qualified after bypass", int'(lk_i), 1);
    pdn_n = 1'b0; #1;
    chk("R10", "lock in powerdown", int'(lk_a), 0);
    pdn_n = 1'b1;
    step(8);
    chk("R10", "lock re-qualified after powerdown", int'(lk_a), 1);

    // R9 loss of lock
    core_lock = 1'b0;
    step(1);
    chk("R9", "lock 1 edge after drop", int'(lk_i), 1);
    step(1);
    chk("R9", "lock 2 edges after drop", int'(lk_i), 0);
    core_lock = 1'b1;
    step(8);
    chk("R9", "relocked", int'(lk_i), 1);

    // R5 / R6 short reset pulse over two edges
    begin
      int rs0;
      rs0 = n_rst_rise_i;
      rst_n = 1'b0; #1;
      chk("R6", "async core_rst immediate", int'(rst_a), 1);
      chk("R10", "async lock dropped", int'(lk_a), 0);
      chk("R5", "sync core_rst not immediate", int'(rst_i), 0);
      step(2);
      rst_n = 1'b1;
      step(2);
      chk("R6", "async core_rst held 2 edges", int'(rst_a), 1);
      step(1);
      chk("R6", "async core_rst released 3rd edge", int'(rst_a), 0);
      chk("R8", "async cal_start in release cycle", int'(cs_a), 1);
      step(1);
      chk("R8", "async cal_start one cycle", int'(cs_a), 0);
      step(10);
      chk("R5", "2-edge pulse ignored", n_rst_rise_i - rs0, 0);
      chk("R5", "sync lock kept", int'(lk_i), 1);
    end

    // R5 three-edge pulse recognised
    begin
      int rs0, c0;
      rs0 = n_rst_rise_i; c0 = n_cal_i;
      rst_n = 1'b0;
      step(3);
      rst_n = 1'b1;
      step(12);
      chk("R5", "3-edge pulse recognised", n_rst_rise_i - rs0, 1);
      chk("R5", "sync core_rst released", int'(rst_i), 0);
      chk("R8", "sync cal pulse after reset", n_cal_i - c0, 1);
      step(8);
      chk("R9", "sync relock after reset", int'(lk_i), 1);
    end

    // R7 supply qualifier, R3 bypass overrides reset
    begin
      int ci0, ca0;
      supply_ok = 1'b0;
      step(5);
      chk("R7", "sync reset held by supply", int'(rst_i), 1);
      chk("R7", "async reset held by supply", int'(rst_a), 1);
      chk("R10", "lock low under supply reset", int'(lk_i), 0);
      byp_n = 1'b0;
      step(10);
      measure("R3", 1);
      byp_n = 1'b1;
      step(1);
      ci0 = n_cal_i; ca0 = n_cal_a;
      supply_ok = 1'b1;
      step(10);
      chk("R7", "sync reset released", int'(rst_i), 0);
      chk("R7", "async reset released", int'(rst_a), 0);
      chk("R8", "sync cal pulse after supply", n_cal_i - ci0, 1);
      chk("R8", "async cal pulse after supply", n_cal_a - ca0, 1);
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #3000000;
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule